// File: doc/BRIEF.md
# Scanned PLC Timer Bank Controller

This block turns one shared RAM into a bank of PLC on-delay timers. Each timer is one 32-bit word. The word holds an in-use flag, the state of the coil that drives the timer, a done flag and a 28-bit count that runs down. A single sequencer serves every timer in turn. On each rising edge of the 1 ms reference tick it walks the words from address 0 to the last address. For each word it reads the word, works out the new value and writes it back. After the last word it waits for the next tick. No timer has a counter of its own.

The host program loads and reloads the counts. To reach the RAM it raises a request. The sequencer stops at the entry it is working on, releases the address and data lines and grants the bus. When the request drops, the sequencer starts that same entry again from its read. Contact changes go to the contact bit area as single-cycle notifications, and only on the scan where the change first happens. The notification carries the timer number.

States: `ST_OFF` is held from reset until the enable is seen. `ST_IDLE` waits for a tick. `ST_READ` drives the address with a read strobe. `ST_EVAL` takes the read data and computes the new word. `ST_WRITE` writes the word back and raises any notification. `ST_HOLD` hands the bus to the host.

Transitions:
- OFF→IDLE when the enable is high.
- IDLE→READ when a tick is pending. The scan starts at address 0.
- READ→EVAL and EVAL→WRITE.
- WRITE→READ with the address plus one, or WRITE→IDLE after the last entry.
- Any of IDLE, READ, EVAL or WRITE → HOLD while the host request is high.
- HOLD→READ on release when a scan was in progress, or HOLD→IDLE otherwise.

Top module: `plc_timer_scanner`

## Requirements
- R1: From reset until `scan_en` is first seen high, the block writes nothing to the RAM, ignores ticks and keeps `host_grant` high.
- R2: Each tick scan writes every entry exactly once, in ascending order from 0 to N_ENTRIES-1. Each write comes two cycles after the read of the same address, and consecutive writes are 3 cycles apart when the host makes no request.
- R3: An entry with bit 31 (in use) = 1, bit 30 (coil) = 1, bit 29 (done) = 0 and a count (bits 27..0) above 1 is written back with the count reduced by one. No other bit changes.
- R4: An entry with bit 31 = 1, bit 30 = 1 and bit 29 = 0 whose count is 0 or 1 is written back with the count 0 and bit 29 set. In the same cycle as that write, `contact_close` pulses with `contact_id` equal to the entry's address.
- R5: An entry with bits 31, 30 and 29 all set is written back unchanged, with no notification.
- R6: An entry with bit 31 = 0 is written back unchanged, with no notification.
- R7: An entry with bit 31 = 1 and bit 30 = 0 is written back with bit 29 cleared and the count kept. `contact_open` pulses with the entry's address only if bit 29 was set. A close and an open notification never occur together.
- R8: While `host_req` is high, `ram_we` stays low. `host_grant` rises one cycle after the request and stays high until the request drops. The interrupted scan then resumes by reading the entry it had stopped at, so no entry is skipped or written twice.
- R9: A tick that arrives during a scan is held. The next scan's first write follows the current scan's last write by exactly 4 cycles.
- R10: Bit 28 of every entry is written back with the value it was read with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (50 MHz) |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1ms | input | 1 | 1 ms reference tick; its rising edge requests a scan |
| scan_en | input | 1 | Enable from the host at initialization |
| host_req | input | 1 | Host asks for the RAM bus |
| ram_rdata | input | 32 | RAM read data, valid the cycle after a read address |
| ram_addr | output | AW | RAM address; 0 when the bus is released |
| ram_re | output | 1 | Read strobe |
| ram_we | output | 1 | Write strobe |
| ram_wdata | output | 32 | Write data; 0 when the bus is released |
| bus_own | output | 1 | Sequencer is driving the RAM bus |
| host_grant | output | 1 | The host may use the RAM bus |
| contact_close | output | 1 | One-cycle notification: the timer's contact closes |
| contact_open | output | 1 | One-cycle notification: the timer's contact opens |
| contact_id | output | AW | Timer number for the notification |

## Verification
The bench builds the block with N_ENTRIES = 8. This gives exactly eight entries, so one scan covers all eight combinations of the in-use, coil and done flags. Four count patterns put counts of 0, 1, 2 and a large value against each combination. Three ticks per pattern then carry the words through decrement, completion and a repeated scan of finished entries. The short scan also makes it cheap to stop the sequencer in the middle with a host request and to overlap a second tick with a running scan. The bench compares every RAM word, every notification count and every write time with a model of the timer rules.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

    localparam int WORD_W = 32;
    localparam int CNT_W  = 28;

    // Field layout of one timer word in RAM
    typedef struct packed {
        logic             in_use;
        logic             coil_on;
        logic             done;
        logic             spare;
        logic [CNT_W-1:0] count;
    } tword_t;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_IDLE,
        ST_READ,
        ST_EVAL,
        ST_WRITE,
        ST_HOLD
    } scan_st_e;

endpackage

// File: rtl/ptmr_tick_catch.sv
module ptmr_tick_catch (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_in,
    input  logic arm,
    input  logic take,
    output logic pending
);

    logic tick_q;
    logic tick_edge;

    assign tick_edge = tick_in & ~tick_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_q  <= 1'b0;
            pending <= 1'b0;
        end else begin
            tick_q <= tick_in;
            if (!arm) begin
                pending <= 1'b0;
            end else begin
                // a fresh edge wins over a take in the same cycle
                pending <= (pending & ~take) | tick_edge;
            end
        end
    end

endmodule

// File: rtl/ptmr_word_update.sv
module ptmr_word_update
    import ptmr_pkg::*;
(
    input  logic [WORD_W-1:0] word_in,
    output logic [WORD_W-1:0] word_out,
    output logic              close_evt,
    output logic              open_evt
);

    tword_t cur;
    tword_t nxt;

    assign cur = tword_t'(word_in);

    always_comb begin
        nxt       = cur;
        close_evt = 1'b0;
        open_evt  = 1'b0;
        if (cur.in_use) begin
            if (!cur.coil_on) begin
                // coil dropped: contact opens once, count left for the host
                nxt.done = 1'b0;
                open_evt = cur.done;
            end else if (!cur.done) begin
                if (cur.count <= CNT_W'(1)) begin
                    nxt.count = '0;
                    nxt.done  = 1'b1;
                    close_evt = 1'b1;
                end else begin
                    nxt.count = cur.count - CNT_W'(1);
                end
            end
        end
    end

    assign word_out = WORD_W'(nxt);

endmodule

// File: rtl/ptmr_scan_seq.sv
module ptmr_scan_seq
    import ptmr_pkg::*;
#(
    parameter int N_ENTRIES = 64,
    parameter int AW        = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scan_en,
    input  logic              host_req,
    input  logic              pending,
    input  logic [WORD_W-1:0] upd_word,
    input  logic              upd_close,
    input  logic              upd_open,
    output logic [AW-1:0]     ram_addr,
    output logic              ram_re,
    output logic              ram_we,
    output logic [WORD_W-1:0] ram_wdata,
    output logic              bus_own,
    output logic              host_grant,
    output logic              contact_close,
    output logic              contact_open,
    output logic [AW-1:0]     contact_id,
    output logic              take,
    output logic              armed
);

    localparam logic [AW-1:0] LAST_ADDR = AW'(N_ENTRIES - 1);

    scan_st_e          state_q;
    scan_st_e          state_d;
    logic [AW-1:0]     addr_q;
    logic              mid_q;
    logic [WORD_W-1:0] wbuf_q;
    logic              close_q;
    logic              open_q;
    logic              is_last;
    logic              own_bus;

    assign is_last = (addr_q == LAST_ADDR);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:   if (scan_en) state_d = ST_IDLE;
            ST_IDLE: begin
                if (host_req)     state_d = ST_HOLD;
                else if (pending) state_d = ST_READ;
            end
            ST_READ:  state_d = host_req ? ST_HOLD : ST_EVAL;
            ST_EVAL:  state_d = host_req ? ST_HOLD : ST_WRITE;
            ST_WRITE: begin
                if (host_req)     state_d = ST_HOLD;
                else if (is_last) state_d = ST_IDLE;
                else              state_d = ST_READ;
            end
            ST_HOLD:  if (!host_req) state_d = mid_q ? ST_READ : ST_IDLE;
            default:  state_d = ST_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // datapath: entry pointer, scan flag and write-back buffer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            mid_q   <= 1'b0;
            wbuf_q  <= '0;
            close_q <= 1'b0;
            open_q  <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && state_d == ST_READ) begin
                addr_q <= '0;
                mid_q  <= 1'b1;
            end
            if (state_q == ST_EVAL && state_d == ST_WRITE) begin
                wbuf_q  <= upd_word;
                close_q <= upd_close;
                open_q  <= upd_open;
            end
            if (state_q == ST_WRITE && state_d == ST_READ) begin
                addr_q <= addr_q + AW'(1);
            end
            if (state_q == ST_WRITE && state_d == ST_IDLE) begin
                mid_q <= 1'b0;
            end
        end
    end

    // outputs
    always_comb begin
        own_bus       = 1'b0;
        ram_re        = 1'b0;
        ram_we        = 1'b0;
        host_grant    = 1'b0;
        take          = 1'b0;
        armed         = 1'b1;
        unique case (state_q)
            ST_OFF: begin
                host_grant = 1'b1;
                armed      = 1'b0;
            end
            ST_IDLE:  take = pending & ~host_req;
            ST_READ: begin
                own_bus = 1'b1;
                ram_re  = ~host_req;
            end
            ST_EVAL:  own_bus = 1'b1;
            ST_WRITE: begin
                own_bus = 1'b1;
                ram_we  = ~host_req;
            end
            ST_HOLD:  host_grant = 1'b1;
            default:  armed = 1'b0;
        endcase
        bus_own       = own_bus;
        ram_addr      = own_bus ? addr_q : '0;
        ram_wdata     = own_bus ? wbuf_q : '0;
        contact_close = ram_we & close_q;
        contact_open  = ram_we & open_q;
        contact_id    = ram_we ? addr_q : '0;
    end

endmodule

// File: rtl/plc_timer_scanner.sv
module plc_timer_scanner
    import ptmr_pkg::*;
#(
    parameter int N_ENTRIES = 64,
    parameter int AW        = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_1ms,
    input  logic          scan_en,
    input  logic          host_req,
    input  logic [31:0]   ram_rdata,
    output logic [AW-1:0] ram_addr,
    output logic          ram_re,
    output logic          ram_we,
    output logic [31:0]   ram_wdata,
    output logic          bus_own,
    output logic          host_grant,
    output logic          contact_close,
    output logic          contact_open,
    output logic [AW-1:0] contact_id
);

    logic              pending;
    logic              take;
    logic              armed;
    logic [WORD_W-1:0] upd_word;
    logic              upd_close;
    logic              upd_open;

    ptmr_tick_catch u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_in (tick_1ms),
        .arm     (armed),
        .take    (take),
        .pending (pending)
    );

    ptmr_word_update u_upd (
        .word_in   (ram_rdata),
        .word_out  (upd_word),
        .close_evt (upd_close),
        .open_evt  (upd_open)
    );

    ptmr_scan_seq #(
        .N_ENTRIES (N_ENTRIES),
        .AW        (AW)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .scan_en       (scan_en),
        .host_req      (host_req),
        .pending       (pending),
        .upd_word      (upd_word),
        .upd_close     (upd_close),
        .upd_open      (upd_open),
        .ram_addr      (ram_addr),
        .ram_re        (ram_re),
        .ram_we        (ram_we),
        .ram_wdata     (ram_wdata),
        .bus_own       (bus_own),
        .host_grant    (host_grant),
        .contact_close (contact_close),
        .contact_open  (contact_open),
        .contact_id    (contact_id),
        .take          (take),
        .armed         (armed)
    );

endmodule

// File: rtl/ptmr_checker.sv
module ptmr_checker #(
    parameter int N_ENTRIES = 64,
    parameter int AW        = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scan_en,
    input logic          host_req,
    input logic [AW-1:0] ram_addr,
    input logic          ram_re,
    input logic          ram_we,
    input logic [31:0]   ram_wdata,
    input logic          host_grant,
    input logic          bus_own,
    input logic          contact_close,
    input logic          contact_open,
    input logic [AW-1:0] contact_id
);

    logic en_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       en_seen <= 1'b0;
        else if (scan_en) en_seen <= 1'b1;
    end

    p_quiet_before_enable_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !en_seen |-> (!ram_we && host_grant));

    p_write_follows_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (ram_addr == $past(ram_addr, 2) && $past(ram_re, 2)));

    p_close_marks_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        contact_close |-> (ram_we && ram_wdata[29] && ram_wdata[27:0] == 28'd0
                           && contact_id == ram_addr));

    p_open_clears_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        contact_open |-> (ram_we && !ram_wdata[29] && !ram_wdata[30]
                          && contact_id == ram_addr));

    p_single_notify_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(contact_close && contact_open));

    p_req_blocks_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        host_req |-> !ram_we);

    p_grant_excludes_bus_r8: assert property (@(posedge clk) disable iff (!rst_n)
        host_grant |-> (!bus_own && !ram_we && !ram_re));

    p_grant_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en_seen && host_grant && host_req) |=> host_grant);

endmodule

bind plc_timer_scanner ptmr_checker #(
    .N_ENTRIES (N_ENTRIES),
    .AW        (AW)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .scan_en       (scan_en),
    .host_req      (host_req),
    .ram_addr      (ram_addr),
    .ram_re        (ram_re),
    .ram_we        (ram_we),
    .ram_wdata     (ram_wdata),
    .host_grant    (host_grant),
    .bus_own       (bus_own),
    .contact_close (contact_close),
    .contact_open  (contact_open),
    .contact_id    (contact_id)
);

// File: tb/plc_timer_scanner_tb_top.sv
`timescale 1ns/1ps
module plc_timer_scanner_tb_top;

    localparam int N  = 8;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_1ms = 1'b0;
    logic          scan_en = 1'b0;
    logic          host_req = 1'b0;
    logic [31:0]   ram_rdata;
    logic [AW-1:0] ram_addr;
    logic          ram_re;
    logic          ram_we;
    logic [31:0]   ram_wdata;
    logic          bus_own;
    logic          host_grant;
    logic          contact_close;
    logic          contact_open;
    logic [AW-1:0] contact_id;

    logic [AW-1:0] h_addr = '0;
    logic [31:0]   h_wdata = '0;
    logic          h_we = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    plc_timer_scanner #(.N_ENTRIES(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_1ms(tick_1ms), .scan_en(scan_en),
        .host_req(host_req), .ram_rdata(ram_rdata), .ram_addr(ram_addr),
        .ram_re(ram_re), .ram_we(ram_we), .ram_wdata(ram_wdata),
        .bus_own(bus_own), .host_grant(host_grant),
        .contact_close(contact_close), .contact_open(contact_open),
        .contact_id(contact_id)
    );

    // single-port RAM model, muxed between sequencer and host
    logic [31:0] mem [N];
    wire [AW-1:0] eff_addr = host_grant ? h_addr : ram_addr;
    always @(posedge clk) begin
        ram_rdata <= mem[eff_addr];
        if (host_grant && h_we) mem[eff_addr] <= h_wdata;
        else if (ram_we)        mem[eff_addr] <= ram_wdata;
    end

    int tests = 0, fails = 0;
    int cyc = 0;
    int log_n = 0;
    int log_addr [64];
    int log_cyc  [64];
    int bad_we = 0;
    int obs_close [N];
    int obs_open  [N];
    int exp_close [N];
    int exp_open  [N];
    logic [31:0] exp_mem [N];
    bit finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor, sampled at the falling edge
    always @(negedge clk) begin
        if (ram_we) begin
            if (log_n < 64) begin
                log_addr[log_n] = int'(ram_addr);
                log_cyc[log_n]  = cyc;
            end
            log_n = log_n + 1;
            if (host_grant || host_req) bad_we = bad_we + 1;
        end
        if (contact_close) obs_close[contact_id] = obs_close[contact_id] + 1;
        if (contact_open)  obs_open[contact_id]  = obs_open[contact_id] + 1;
    end

    task automatic check(input string req, input string what, input longint act, input longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // timer rules as stated in the requirements: {close, open, word}
    function automatic logic [33:0] mstep(input logic [31:0] w);
        logic [31:0] n = w;
        logic c = 1'b0, o = 1'b0;
        if (w[31]) begin
            if (!w[30]) begin
                n[29] = 1'b0;
                o = w[29];
            end else if (!w[29]) begin
                if (w[27:0] <= 28'd1) begin
                    n[27:0] = 28'd0;
                    n[29] = 1'b1;
                    c = 1'b1;
                end else begin
                    n[27:0] = w[27:0] - 28'd1;
                end
            end
        end
        return {c, o, n};
    endfunction

    function automatic string rule_of(input logic [31:0] w);
        if (!w[31]) return "R6";
        if (!w[30]) return "R7";
        if (w[29])  return "R5";
        if (w[27:0] <= 28'd1) return "R4";
        return "R3";
    endfunction

    task automatic step_model();
        for (int i = 0; i < N; i++) begin
            logic [33:0] r = mstep(exp_mem[i]);
            exp_close[i] += int'(r[33]);
            exp_open[i]  += int'(r[32]);
            exp_mem[i]   = r[31:0];
        end
    endtask

    task automatic drive_cycle();
        @(posedge clk); #2;
    endtask

    task automatic host_acquire();
        host_req = 1'b1;
        for (int k = 0; k < 20 && !host_grant; k++) drive_cycle();
        check("R8", "grant after request", host_grant, 1);
    endtask

    task automatic host_write(input int a, input logic [31:0] d);
        h_addr = AW'(a); h_wdata = d; h_we = 1'b1;
        drive_cycle();
        h_we = 1'b0;
    endtask

    task automatic pulse_tick();
        tick_1ms = 1'b1; drive_cycle(); tick_1ms = 1'b0;
    endtask

    task automatic wait_writes(input int n);
        for (int k = 0; k < 400 && log_n < n; k++) drive_cycle();
        drive_cycle(); drive_cycle();
    endtask

    task automatic compare_all(input string ctx);
        for (int i = 0; i < N; i++) begin
            check(rule_of(exp_mem[i]), $sformatf("%s word %0d", ctx, i),
                  mem[i], exp_mem[i]);
            check("R10", $sformatf("%s bit28 %0d", ctx, i), mem[i][28], exp_mem[i][28]);
            check("R4", $sformatf("%s close cnt %0d", ctx, i), obs_close[i], exp_close[i]);
            check("R7", $sformatf("%s open cnt %0d", ctx, i), obs_open[i], exp_open[i]);
        end
    endtask

    task automatic check_order(input string ctx, input int base, input int gap);
        for (int i = 0; i < N; i++) begin
            check("R2", $sformatf("%s write addr #%0d", ctx, i), log_addr[base+i], i);
            if (i > 0 && gap > 0)
                check("R2", $sformatf("%s write spacing #%0d", ctx, i),
                      log_cyc[base+i] - log_cyc[base+i-1], gap);
        end
    endtask

    function automatic logic [31:0] pattern_word(input int p, input int i);
        logic [31:0] w = '0;
        int sel = (i + p) % 4;
        w[31] = i[2]; w[30] = i[1]; w[29] = i[0];
        w[28] = p[0] ^ i[0];
        w[27:0] = (sel == 3) ? 28'h0FF_FFFF : 28'(sel);
        return w;
    endfunction

    task automatic load_pattern(input int p);
        host_acquire();
        for (int i = 0; i < N; i++) begin
            exp_mem[i] = pattern_word(p, i);
            host_write(i, exp_mem[i]);
        end
        host_req = 1'b0;
        drive_cycle(); drive_cycle();
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            mem[i] = '0; exp_mem[i] = '0;
            obs_close[i] = 0; obs_open[i] = 0; exp_close[i] = 0; exp_open[i] = 0;
        end
        repeat (3) drive_cycle();
        // R1: reset state
        check("R1", "reset ram_we", ram_we, 0);
        check("R1", "reset host_grant", host_grant, 1);
        check("R1", "reset ram_addr", ram_addr, 0);
        check("R1", "reset bus_own", bus_own, 0);
        rst_n = 1'b1;
        drive_cycle();
        for (int i = 0; i < N; i++) begin
            exp_mem[i] = pattern_word(0, i);
            host_write(i, exp_mem[i]);
        end
        // R1: ticks before enable do nothing
        pulse_tick();
        repeat (40) drive_cycle();
        check("R1", "writes before enable", log_n, 0);
        check("R1", "grant before enable", host_grant, 1);
        compare_all("pre-enable");

        scan_en = 1'b1;
        drive_cycle(); drive_cycle();

        // flag/count sweep: four patterns, three scans each
        for (int p = 0; p < 4; p++) begin
            if (p > 0) load_pattern(p);
            for (int t = 0; t < 3; t++) begin
                log_n = 0;
                pulse_tick();
                wait_writes(N);
                step_model();
                check("R2", $sformatf("p%0d t%0d write count", p, t), log_n, N);
                check_order($sformatf("p%0d t%0d", p, t), 0, 3);
                compare_all($sformatf("p%0d t%0d", p, t));
            end
        end

        // R8: host request in the middle of a scan
        load_pattern(1);
        for (int stop = 2; stop < 5; stop++) begin
            log_n = 0;
            pulse_tick();
            for (int k = 0; k < 100 && log_n < stop; k++) drive_cycle();
            host_req = 1'b1;
            drive_cycle();
            check("R8", "grant one cycle after request", host_grant, 1);
            exp_mem[7] = {4'b1100, 28'd5 + 28'(stop)};
            host_write(7, exp_mem[7]);
            repeat (8) drive_cycle();
            check("R8", "grant held", host_grant, 1);
            check("R8", "no writes while held", log_n, stop);
            host_req = 1'b0;
            wait_writes(N);
            step_model();
            check("R8", "write count after resume", log_n, N);
            check_order("resume", 0, 0);
            compare_all("resume");
        end
        check("R8", "writes during grant or request", bad_we, 0);

        // R9: second tick during a scan
        log_n = 0;
        pulse_tick();
        repeat (4) drive_cycle();
        pulse_tick();
        wait_writes(2 * N);
        step_model();
        step_model();
        check("R9", "write count for two scans", log_n, 2 * N);
        check_order("first of two", 0, 3);
        check_order("second of two", N, 3);
        check("R9", "gap between scans", log_cyc[N] - log_cyc[N-1], 4);
        compare_all("double tick");

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule